// File: doc/BRIEF.md
# Large-ROM Cartridge Chip-Select Decoder

This block sits on the cartridge side of a 16-bit-era console's 24-bit address bus. It has no bank registers. It spreads roughly 95 Mbit of ROM over three 32 Mbit chips and adds one 8 KiB save RAM. The address is split into a bank byte (bits 23..16) and a 16-bit offset.

- The **low-style chip** serves the half of the bank space where address bit 22 is clear. Only the upper 32 KiB of each bank reaches it, so CPU bit 15 is dropped when its local address is built.
- The **two high-style chips** serve the half where bit 22 is set. Each takes whole 64 KiB banks. Bit 23 chooses between the chip for banks 40-7D and the chip for banks C0-FF.

Banks 7E-7F belong to the console's work RAM and are never claimed. Every enable is active low and is also qualified by the active-low read strobe.

The decoder is purely combinational. The bench applies an address and strobe, then reads four enables and four local addresses in the same cycle.

Top module: `big_rom_decoder`

## Requirements
- R1: With bit 22 clear, banks 00-3F and 80-BF at offsets 8000-FFFF assert only `lo_rom_oe_n`.
- R2: Banks 40-7D at any offset assert only `mid_rom_oe_n`.
- R3: Banks C0-FF at any offset assert only `top_rom_oe_n`.
- R4: Banks 7E and 7F never assert any enable.
- R5: At most one of the four enables is low at any time.
- R6: While `rd_n` is high, all four enables are high.
- R7: `lo_rom_addr` equals {cpu_addr[23], cpu_addr[21:16], cpu_addr[14:0]}, so CPU bit 15 is skipped.
- R8: `mid_rom_addr` and `top_rom_addr` both equal cpu_addr[21:0].
- R9: Banks 20-3F and A0-BF at offsets 6000-7FFF assert `ram_oe_n` and no ROM enable; `ram_addr` equals cpu_addr[12:0].
- R10: Banks 00-3F and 80-BF at offsets 0000-7FFF outside the save-RAM window assert no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 24 | CPU address: bank in bits 23..16, offset in bits 15..0 |
| rd_n | input | 1 | Active-low read strobe |
| lo_rom_oe_n | output | 1 | Output enable, low-style ROM |
| mid_rom_oe_n | output | 1 | Output enable, high-style ROM for banks 40-7D |
| top_rom_oe_n | output | 1 | Output enable, high-style ROM for banks C0-FF |
| ram_oe_n | output | 1 | Output enable, save RAM |
| lo_rom_addr | output | 22 | Local address, low-style ROM |
| mid_rom_addr | output | 22 | Local address, banks 40-7D ROM |
| top_rom_addr | output | 22 | Local address, banks C0-FF ROM |
| ram_addr | output | 13 | Local address, save RAM |

## Verification
The directed cases sit on the edges of each region, and each one catches a specific decoding mistake:

| Case | What a faulty decoder does |
|---|---|
| Banks 7D, 7E, 7F and FE, FF | Claims work RAM if it tests only bit 22, or drops the top ROM's last banks if the work-RAM exclusion ignores bit 23 |
| Offsets 7FFF and 8000 in banks 00-3F / 80-BF | Lets the low chip drive in the lower half of the bank |
| Save-RAM corners 1F:6000, 20:5FFF, 20:6000, BF:7FFF | Lets RAM and ROM collide at the window edges |
| Addresses with bit 15 set versus clear | Shows a low-chip address that keeps bit 15, or drops bit 23, by aliasing two distinct CPU addresses |

Randomized addresses, with the read strobe sometimes high, cover everything in between. They are checked against a reference model written from the requirements.

// File: rtl/big_rom_decoder_pkg.sv
// Shared constants and types for the large-ROM chip-select decoder.
// Assumes a 24-bit address split into an 8-bit bank and a 16-bit offset.
package big_rom_decoder_pkg;

    localparam int ADDR_W    = 24;
    localparam int OFFS_W    = 16;
    localparam int BANK_W    = ADDR_W - OFFS_W;
    localparam int CHIP_AW   = 22;
    localparam int RAM_AW    = 13;
    localparam int SKIP_BIT  = 15;
    localparam int SPLIT_BIT = 22;
    localparam int SIDE_BIT  = ADDR_W - 1;

    // Which device owns the current bus cycle.
    typedef enum logic [2:0] {
        OWNER_NONE,
        OWNER_LO,
        OWNER_MID,
        OWNER_TOP,
        OWNER_RAM
    } owner_e;

endpackage

// File: rtl/big_rom_region_dec.sv
// Region decoder: classifies a CPU address as one of the three ROM areas,
// the save-RAM window, or nothing. Read qualification happens in the top.
// Assumes bank in the upper BANK_W bits and work RAM in banks 7E-7F.
module big_rom_region_dec
    import big_rom_decoder_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output owner_e            owner
);

    localparam logic [BANK_W-2:0] WRAM_PAIR = 7'h3F;

    logic [BANK_W-1:0] bank;
    logic              in_wram;
    logic              upper_half;
    logic              ram_window;
    logic              unused_low_bits;

    assign bank            = addr[ADDR_W-1:OFFS_W];
    assign upper_half      = addr[SKIP_BIT];
    assign unused_low_bits = ^addr[RAM_AW-1:0];

    // Flag banks 7E-7F and the save-RAM window.
    always_comb begin
        in_wram    = (bank[BANK_W-1] == 1'b0) && (bank[BANK_W-2:1] == WRAM_PAIR);
        ram_window = (bank[SPLIT_BIT-OFFS_W:BANK_W-3] == 2'b01) &&
                     (addr[OFFS_W-1:RAM_AW] == 3'b011);
    end

    // Pick the single owner of this address.
    always_comb begin
        owner = OWNER_NONE;
        if (addr[SPLIT_BIT]) begin
            if (addr[SIDE_BIT])
                owner = OWNER_TOP;
            else if (!in_wram)
                owner = OWNER_MID;
        end else if (upper_half) begin
            owner = OWNER_LO;
        end else if (ram_window) begin
            owner = OWNER_RAM;
        end
    end

endmodule

// File: rtl/big_rom_addr_form.sv
// Local address former for one ROM chip.
// SKIP_A15 = 1 gives the low-style layout: CPU bit 15 is dropped, the bank
// bits below the split bit shift down by one, and the side bit becomes the
// chip MSB. SKIP_A15 = 0 passes the low CHIP_AW bits straight through.
module big_rom_addr_form
    import big_rom_decoder_pkg::*;
#(
    parameter bit SKIP_A15 = 1'b0
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [CHIP_AW-1:0] chip_addr
);

    generate
        if (SKIP_A15) begin : g_low_style
            logic unused_bits;

            assign unused_bits = addr[SKIP_BIT] ^ addr[SPLIT_BIT];

            // Squeeze out bit 15 and put the side bit on top.
            always_comb begin
                chip_addr = {addr[SIDE_BIT],
                             addr[SPLIT_BIT-1:SKIP_BIT+1],
                             addr[SKIP_BIT-1:0]};
            end
        end else begin : g_high_style
            logic unused_bits;

            assign unused_bits = ^addr[ADDR_W-1:CHIP_AW];

            // Use the address bits unchanged.
            always_comb begin
                chip_addr = addr[CHIP_AW-1:0];
            end
        end
    endgenerate

endmodule

// File: rtl/big_rom_decoder.sv
// Top of the large-ROM cartridge decoder. Purely combinational.
// Turns the region owner into active-low enables qualified by rd_n, and
// builds each chip's local address. Assumes no bank switching.
module big_rom_decoder
    import big_rom_decoder_pkg::*;
(
    input  logic [23:0] cpu_addr,
    input  logic        rd_n,
    output logic        lo_rom_oe_n,
    output logic        mid_rom_oe_n,
    output logic        top_rom_oe_n,
    output logic        ram_oe_n,
    output logic [21:0] lo_rom_addr,
    output logic [21:0] mid_rom_addr,
    output logic [21:0] top_rom_addr,
    output logic [12:0] ram_addr
);

    owner_e owner;

    big_rom_region_dec u_region (
        .addr  (cpu_addr),
        .owner (owner)
    );

    big_rom_addr_form #(.SKIP_A15(1'b1)) u_lo_addr (
        .addr      (cpu_addr),
        .chip_addr (lo_rom_addr)
    );

    big_rom_addr_form #(.SKIP_A15(1'b0)) u_mid_addr (
        .addr      (cpu_addr),
        .chip_addr (mid_rom_addr)
    );

    big_rom_addr_form #(.SKIP_A15(1'b0)) u_top_addr (
        .addr      (cpu_addr),
        .chip_addr (top_rom_addr)
    );

    assign ram_addr = cpu_addr[RAM_AW-1:0];

    // Drive the active-low enables, and only while a read is in progress.
    always_comb begin
        lo_rom_oe_n  = !(!rd_n && owner == OWNER_LO);
        mid_rom_oe_n = !(!rd_n && owner == OWNER_MID);
        top_rom_oe_n = !(!rd_n && owner == OWNER_TOP);
        ram_oe_n     = !(!rd_n && owner == OWNER_RAM);
    end

    // Check the enables against the address and strobe ports.
    always_comb begin
        if (!$isunknown({cpu_addr, rd_n})) begin
            // R5: at most one enable active
            a_r5_one_enable: assert ($onehot0({~lo_rom_oe_n, ~mid_rom_oe_n,
                                               ~top_rom_oe_n, ~ram_oe_n}))
                else $error("R5 violated");
            // R6: no enable without a read
            if (rd_n)
                a_r6_idle_quiet: assert ({lo_rom_oe_n, mid_rom_oe_n,
                                          top_rom_oe_n, ram_oe_n} == 4'hF)
                    else $error("R6 violated");
            // R4: work RAM banks never claimed
            if (cpu_addr[23:17] == 7'h3F)
                a_r4_wram_free: assert ({lo_rom_oe_n, mid_rom_oe_n,
                                         top_rom_oe_n, ram_oe_n} == 4'hF)
                    else $error("R4 violated");
            // R1: bit 22 clear keeps both high-style chips off
            if (!cpu_addr[22])
                a_r1_split_low: assert (mid_rom_oe_n && top_rom_oe_n)
                    else $error("R1 violated");
            // R3: bit 23 high never enables the banks 40-7D chip
            if (cpu_addr[23])
                a_r3_side_top: assert (mid_rom_oe_n)
                    else $error("R3 violated");
        end
    end

endmodule

// File: tb/big_rom_decoder_tb_top.sv
// Self-checking bench for big_rom_decoder. The 200 MHz clock only paces
// the stimulus: inputs change on the rising edge, outputs are read on
// the falling edge.
module big_rom_decoder_tb_top;

    logic        clk = 1'b0;
    logic [23:0] cpu_addr;
    logic        rd_n;
    logic        lo_rom_oe_n, mid_rom_oe_n, top_rom_oe_n, ram_oe_n;
    logic [21:0] lo_rom_addr, mid_rom_addr, top_rom_addr;
    logic [12:0] ram_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    big_rom_decoder dut_i (
        .cpu_addr     (cpu_addr),
        .rd_n         (rd_n),
        .lo_rom_oe_n  (lo_rom_oe_n),
        .mid_rom_oe_n (mid_rom_oe_n),
        .top_rom_oe_n (top_rom_oe_n),
        .ram_oe_n     (ram_oe_n),
        .lo_rom_addr  (lo_rom_addr),
        .mid_rom_addr (mid_rom_addr),
        .top_rom_addr (top_rom_addr),
        .ram_addr     (ram_addr)
    );

    // Reference enables {lo, mid, top, ram}, active low, from the requirements.
    function automatic logic [3:0] ref_oe(input logic [23:0] a, input logic rn);
        logic [7:0]  bank;
        logic [15:0] offs;
        logic [3:0]  act;

        bank = a[23:16];
        offs = a[15:0];
        act  = 4'b0000;
        if (bank >= 8'hC0)
            act = 4'b0010;                                     // R3
        else if (bank >= 8'h40 && bank <= 8'h7D)
            act = 4'b0100;                                     // R2
        else if (bank >= 8'h7E && bank <= 8'h7F)
            act = 4'b0000;                                     // R4
        else if (offs >= 16'h8000)
            act = 4'b1000;                                     // R1
        else if (((bank >= 8'h20 && bank <= 8'h3F) ||
                  (bank >= 8'hA0 && bank <= 8'hBF)) &&
                 offs >= 16'h6000)
            act = 4'b0001;                                     // R9
        if (rn)
            act = 4'b0000;                                     // R6
        return ~act;
    endfunction

    function automatic logic [21:0] ref_lo_addr(input logic [23:0] a);
        return {a[23], a[21:16], a[14:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] got,
                         input logic [31:0] exp, input logic [23:0] a);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%06h actual=%0h expected=%0h", tag, a, got, exp);
        end
    endtask

    // Apply one address and strobe, then check every output.
    task automatic apply(input logic [23:0] a, input logic rn);
        logic [3:0] exp_oe;
        logic [3:0] got_oe;
        string      tag;

        @(posedge clk);
        cpu_addr = a;
        rd_n     = rn;
        @(negedge clk);
        exp_oe = ref_oe(a, rn);
        got_oe = {lo_rom_oe_n, mid_rom_oe_n, top_rom_oe_n, ram_oe_n};
        if (rn)                                   tag = "R6";
        else if (a[23:17] == 7'h3F)               tag = "R4";
        else if (a[23:22] == 2'b11)               tag = "R3";
        else if (a[22])                           tag = "R2";
        else if (!exp_oe[0])                      tag = "R9";
        else if (a[15])                           tag = "R1";
        else                                      tag = "R10";
        check(tag, 32'(got_oe), 32'(exp_oe), a);
        check("R5", 32'($countones(~got_oe) <= 1), 32'd1, a);
        check("R7", 32'(lo_rom_addr), 32'(ref_lo_addr(a)), a);
        check("R8", 32'(mid_rom_addr), 32'(a[21:0]), a);
        check("R8", 32'(top_rom_addr), 32'(a[21:0]), a);
        check("R9", 32'(ram_addr), 32'(a[12:0]), a);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] a;
        logic        rn;

        cpu_addr = 24'h0;
        rd_n     = 1'b1;
        void'($urandom(32'h5EED_1234));

        // Idle state: strobe high with an address that would otherwise hit ROM.
        apply(24'hC0_0000, 1'b1);   // R6
        apply(24'h00_8000, 1'b1);   // R6

        // R1 and R10: edges of the low-style area
        apply(24'h00_7FFF, 1'b0);   // R10
        apply(24'h00_8000, 1'b0);   // R1
        apply(24'h3F_FFFF, 1'b0);   // R1
        apply(24'h80_8000, 1'b0);   // R1
        apply(24'hBF_FFFF, 1'b0);   // R1
        apply(24'h80_0000, 1'b0);   // R10
        // R2 and R4: banks 40-7D versus work RAM
        apply(24'h40_0000, 1'b0);   // R2
        apply(24'h7D_FFFF, 1'b0);   // R2
        apply(24'h7E_0000, 1'b0);   // R4
        apply(24'h7F_FFFF, 1'b0);   // R4
        apply(24'h7E_8000, 1'b0);   // R4
        // R3: the top chip, including FE-FF
        apply(24'hC0_0000, 1'b0);   // R3
        apply(24'hFE_1234, 1'b0);   // R3
        apply(24'hFF_FFFF, 1'b0);   // R3
        // R9: save-RAM window corners
        apply(24'h20_6000, 1'b0);   // R9
        apply(24'h3F_7FFF, 1'b0);   // R9
        apply(24'hA0_6000, 1'b0);   // R9
        apply(24'hBF_7FFF, 1'b0);   // R9
        apply(24'h1F_6000, 1'b0);   // R10
        apply(24'h20_5FFF, 1'b0);   // R10
        apply(24'hC0_6000, 1'b0);   // R3
        // R7: bit 15 skipped, bit 23 kept as chip MSB
        apply(24'h01_8000, 1'b0);   // R7
        apply(24'h81_8000, 1'b0);   // R7

        // Random addresses, with the strobe high about one time in eight.
        for (int i = 0; i < 3000; i++) begin
            a  = 24'($urandom);
            rn = ($urandom_range(7) == 0);
            apply(a, rn);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule